// File: doc/BRIEF.md
# Status Word Control and Mask Insertion

This block keeps the processor status word: a 64-bit mask word and a 64-bit instruction address. The mask word holds a 2-bit address-space mode field and a 4-bit program mask. Three operations act on it. Each one is started by a single-cycle strobe from the instruction decoder.

The insert operation takes a 64-bit general-register value and returns it with bits 31:24 replaced by the condition code and the program mask. The set-mode operation reads a 4-bit code from an operand and switches the address-space mode. A code that is not defined leaves the mode as it was and raises a specification exception. The load operation writes a new mask word and a new address together. It then pulses a flush so that fetch restarts at the new address.

All results are registered. They appear one clock after the strobe. The register file and the decode logic are outside this block.

Top module: `psw_ctrl`

## Requirements
- R1: After reset the mask word and address are zero, `mode_o` is 2'b00 (primary), and `gr_vld_o`, `flush_o` and `spec_exc_o` are low.
- R2: A set-mode strobe with operand bits 11:8 equal to 0x0, 0x1 or 0x3 sets mode 2'b00 (primary), 2'b10 (secondary) or 2'b11 (home). The mode is stored in mask bits 47:46 and shows on `mode_o` in the next cycle.
- R3: A set-mode strobe with any other code leaves the mode and mask unchanged. In the next cycle it pulses `spec_exc_o` for one cycle, with `ilc_o` equal to 2.
- R4: An insert strobe yields `gr_o` one cycle later with `gr_vld_o` high. Bits 63:32 and 23:0 are copied from the input value, and bits 31:30 are zero.
- R5: The inserted result carries the 2-bit condition code in bits 29:28.
- R6: The inserted result carries the program mask, taken from mask-word bits 43:40, in bits 27:24.
- R7: A load strobe replaces the mask word and the address together. The new values show on `psw_mask_o`, `psw_addr_o` and `mode_o` in the next cycle.
- R8: Every load strobe is followed in the next cycle by `flush_o` high. `flush_o` is low in any cycle that does not follow a load.
- R9: An insert strobe in the same cycle as a load uses the program mask from before the load.
- R10: A load strobe in the same cycle as a set-mode strobe takes precedence. The mode comes from the loaded mask word, and no exception is raised even for an invalid code.
- R11: The set-mode operation ignores every operand bit except bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_i | input | 1 | Insert strobe |
| ins_gr_i | input | 64 | General-register value to be updated |
| cc_i | input | 2 | Current condition code |
| sac_i | input | 1 | Set-mode strobe |
| sac_op_i | input | 64 | Set-mode operand; code in bits 11:8 |
| ld_i | input | 1 | Load strobe |
| ld_mask_i | input | 64 | New mask word |
| ld_addr_i | input | 64 | New instruction address |
| gr_o | output | 64 | Updated register value |
| gr_vld_o | output | 1 | gr_o valid, one-cycle pulse |
| mode_o | output | 2 | Current address-space mode |
| psw_mask_o | output | 64 | Current mask word |
| psw_addr_o | output | 64 | Current instruction address |
| flush_o | output | 1 | Fetch restart pulse after a load |
| spec_exc_o | output | 1 | Specification exception pulse |
| ilc_o | output | 2 | Instruction length code for the exception |

## Verification
A load can land in the same cycle as an insert or as a set-mode strobe. In the first case the inserted program mask must be the one from before the load. In the second case the load must win and suppress any exception. The bench drives both pairings, with both valid and invalid set-mode codes. It then checks the inserted nibble against the old mask and confirms the mode that results. It also checks that `spec_exc_o` stays low.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned ASC_LSB   = 46;
  localparam int unsigned PM_LSB    = 40;
  localparam int unsigned PM_W      = 4;
  localparam int unsigned CODE_LSB  = 8;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned ILC_W     = 2;
  localparam logic [1:0]  SPEC_ILC  = 2'd2;

  typedef enum logic [1:0] {
    ASC_PRI  = 2'b00,
    ASC_AR   = 2'b01,
    ASC_SEC  = 2'b10,
    ASC_HOME = 2'b11
  } asc_e;
endpackage

// File: rtl/psw_asc_dec.sv
module psw_asc_dec
  import psw_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              ok_o,
  output asc_e              mode_o
);
  // sparse code space: only 0, 1 and 3 are defined
  always_comb begin
    ok_o   = 1'b1;
    mode_o = ASC_PRI;
    case (code_i)
      4'h0:    mode_o = ASC_PRI;
      4'h1:    mode_o = ASC_SEC;
      4'h3:    mode_o = ASC_HOME;
      default: ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_state.sv
module psw_state
  import psw_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [W-1:0]     ld_mask_i,
  input  logic [W-1:0]     ld_addr_i,
  input  logic             sac_i,
  input  logic             sac_ok_i,
  input  asc_e             sac_mode_i,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     addr_o,
  output logic             flush_o,
  output logic             exc_o,
  output logic [ILC_W-1:0] ilc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      addr_o  <= '0;
      flush_o <= 1'b0;
      exc_o   <= 1'b0;
      ilc_o   <= '0;
    end else begin
      flush_o <= ld_i;
      exc_o   <= 1'b0;
      if (ld_i) begin
        // load wins over a concurrent set-mode
        mask_o <= ld_mask_i;
        addr_o <= ld_addr_i;
      end else if (sac_i) begin
        if (sac_ok_i) begin
          mask_o[ASC_LSB +: 2] <= sac_mode_i;
        end else begin
          exc_o <= 1'b1;
          ilc_o <= SPEC_ILC;
        end
      end
    end
  end

  p_good_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sac_i && sac_ok_i && !ld_i) |=> mask_o[ASC_LSB +: 2] == $past(sac_mode_i));
  p_bad_code_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sac_i && !sac_ok_i && !ld_i) |=> ($stable(mask_o) && exc_o && ilc_o == SPEC_ILC));
  p_load_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (mask_o == $past(ld_mask_i) && addr_o == $past(ld_addr_i)));
  p_flush_after_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> flush_o);
  p_no_flush_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> !flush_o);
  p_load_masks_exc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !exc_o);
endmodule

// File: rtl/psw_ipm.sv
module psw_ipm
  import psw_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ins_i,
  input  logic [W-1:0]    gr_i,
  input  logic [1:0]      cc_i,
  input  logic [PM_W-1:0] pm_i,
  output logic [W-1:0]    gr_o,
  output logic            vld_o
);
  logic [7:0] unused_gr;
  assign unused_gr = gr_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gr_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= ins_i;
      if (ins_i) gr_o <= {gr_i[W-1:32], 2'b00, cc_i, pm_i, gr_i[23:0]};
    end
  end

  p_keep_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> (vld_o && gr_o[W-1:32] == $past(gr_i[W-1:32])
               && gr_o[23:0] == $past(gr_i[23:0]) && gr_o[31:30] == 2'b00));
  p_cc_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> gr_o[29:28] == $past(cc_i));
  p_pm_field_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> gr_o[27:24] == $past(pm_i));
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [63:0]      ins_gr_i,
  input  logic [1:0]       cc_i,
  input  logic             sac_i,
  input  logic [63:0]      sac_op_i,
  input  logic             ld_i,
  input  logic [63:0]      ld_mask_i,
  input  logic [63:0]      ld_addr_i,
  output logic [63:0]      gr_o,
  output logic             gr_vld_o,
  output logic [1:0]       mode_o,
  output logic [63:0]      psw_mask_o,
  output logic [63:0]      psw_addr_o,
  output logic             flush_o,
  output logic             spec_exc_o,
  output logic [ILC_W-1:0] ilc_o
);
  logic sac_ok;
  asc_e sac_mode;
  logic unused_op;

  // only the mode code field of the operand is examined
  assign unused_op = ^{sac_op_i[XLEN-1:CODE_LSB+CODE_W], sac_op_i[CODE_LSB-1:0]};

  psw_asc_dec u_dec (
    .code_i (sac_op_i[CODE_LSB +: CODE_W]),
    .ok_o   (sac_ok),
    .mode_o (sac_mode)
  );

  psw_state #(.W(XLEN)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (ld_i),
    .ld_mask_i  (ld_mask_i),
    .ld_addr_i  (ld_addr_i),
    .sac_i      (sac_i),
    .sac_ok_i   (sac_ok),
    .sac_mode_i (sac_mode),
    .mask_o     (psw_mask_o),
    .addr_o     (psw_addr_o),
    .flush_o    (flush_o),
    .exc_o      (spec_exc_o),
    .ilc_o      (ilc_o)
  );

  // insert reads the registered mask, so a same-cycle load is not yet visible
  psw_ipm #(.W(XLEN)) u_ipm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ins_i  (ins_i),
    .gr_i   (ins_gr_i),
    .cc_i   (cc_i),
    .pm_i   (psw_mask_o[PM_LSB +: PM_W]),
    .gr_o   (gr_o),
    .vld_o  (gr_vld_o)
  );

  assign mode_o = psw_mask_o[ASC_LSB +: 2];

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!spec_exc_o && !flush_o && !gr_vld_o));
  p_ins_old_pm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && ld_i) |=> gr_o[27:24] == $past(psw_mask_o[PM_LSB +: PM_W]));
endmodule

// File: tb/psw_ctrl_tb_top.sv
module psw_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ins_i = 1'b0, sac_i = 1'b0, ld_i = 1'b0;
  logic [63:0] ins_gr_i = '0, sac_op_i = '0, ld_mask_i = '0, ld_addr_i = '0;
  logic [1:0]  cc_i = '0;
  logic [63:0] gr_o, psw_mask_o, psw_addr_o;
  logic        gr_vld_o, flush_o, spec_exc_o;
  logic [1:0]  mode_o, ilc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ins_i(ins_i), .ins_gr_i(ins_gr_i), .cc_i(cc_i),
    .sac_i(sac_i), .sac_op_i(sac_op_i), .ld_i(ld_i), .ld_mask_i(ld_mask_i),
    .ld_addr_i(ld_addr_i), .gr_o(gr_o), .gr_vld_o(gr_vld_o), .mode_o(mode_o),
    .psw_mask_o(psw_mask_o), .psw_addr_o(psw_addr_o), .flush_o(flush_o),
    .spec_exc_o(spec_exc_o), .ilc_o(ilc_o)
  );

  typedef struct {
    string       tag;
    logic        vld;
    logic [63:0] gr;
    logic [1:0]  mode;
    logic [63:0] mask;
    logic [63:0] addr;
    logic        flush;
    logic        exc;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  logic [63:0] mask_m = '0, addr_m = '0;
  bit done = 0;

  task automatic step(input string tag, input bit ins, input logic [63:0] gr,
                      input logic [1:0] cc, input bit sac, input logic [63:0] op,
                      input bit ld, input logic [63:0] lmask, input logic [63:0] laddr);
    exp_t e;
    @(negedge clk);
    ins_i = ins; ins_gr_i = gr; cc_i = cc; sac_i = sac; sac_op_i = op;
    ld_i = ld; ld_mask_i = lmask; ld_addr_i = laddr;
    e.tag = tag;
    e.vld = ins;
    e.gr  = {gr[63:32], 2'b00, cc, mask_m[43:40], gr[23:0]};
    e.flush = ld;
    e.exc = 1'b0;
    if (ld) begin
      mask_m = lmask; addr_m = laddr;
    end else if (sac) begin
      case (op[11:8])
        4'h0: mask_m[47:46] = 2'b00;
        4'h1: mask_m[47:46] = 2'b10;
        4'h3: mask_m[47:46] = 2'b11;
        default: e.exc = 1'b1;
      endcase
    end
    e.mode = mask_m[47:46];
    e.mask = mask_m;
    e.addr = addr_m;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, 2'd0, 0, '0, 0, '0, '0);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && q.size() > 0) begin
        exp_t e;
        bit   ok;
        e = q.pop_front();
        ok = 1;
        total++;
        if (gr_vld_o !== e.vld) begin
          ok = 0; $display("FAIL %s gr_vld_o act=%0b exp=%0b", e.tag, gr_vld_o, e.vld);
        end
        if (e.vld && gr_o !== e.gr) begin
          ok = 0; $display("FAIL %s gr_o act=%h exp=%h", e.tag, gr_o, e.gr);
        end
        if (mode_o !== e.mode) begin
          ok = 0; $display("FAIL %s mode_o act=%b exp=%b", e.tag, mode_o, e.mode);
        end
        if (psw_mask_o !== e.mask) begin
          ok = 0; $display("FAIL %s psw_mask_o act=%h exp=%h", e.tag, psw_mask_o, e.mask);
        end
        if (psw_addr_o !== e.addr) begin
          ok = 0; $display("FAIL %s psw_addr_o act=%h exp=%h", e.tag, psw_addr_o, e.addr);
        end
        if (flush_o !== e.flush) begin
          ok = 0; $display("FAIL %s flush_o act=%0b exp=%0b", e.tag, flush_o, e.flush);
        end
        if (spec_exc_o !== e.exc) begin
          ok = 0; $display("FAIL %s spec_exc_o act=%0b exp=%0b", e.tag, spec_exc_o, e.exc);
        end
        if (e.exc && ilc_o !== 2'd2) begin
          ok = 0; $display("FAIL %s ilc_o act=%0d exp=2", e.tag, ilc_o);
        end
        if (!ok) bad++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    idle("R1");
    idle("R1");
    // R2 valid codes
    step("R2", 0, '0, 0, 1, 64'h0000_0000_0000_0100, 0, '0, '0);
    step("R11", 0, '0, 0, 1, 64'hFFFF_FFFF_FFFF_F3FF, 0, '0, '0);
    step("R11", 0, '0, 0, 1, 64'hABCD_0000_1234_F0FF, 0, '0, '0);
    step("R2", 0, '0, 0, 1, 64'h0000_0000_0000_0300, 0, '0, '0);
    // R3 invalid codes keep home mode
    step("R3", 0, '0, 0, 1, 64'h0000_0000_0000_0200, 0, '0, '0);
    idle("R3");
    step("R3", 0, '0, 0, 1, 64'h0000_0000_0000_0400, 0, '0, '0);
    step("R3", 0, '0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0, '0);
    // R4 R5 insert with zero program mask
    step("R4", 1, 64'hDEAD_BEEF_A5C3_1234, 2'd2, 0, '0, 0, '0, '0);
    step("R5", 1, 64'h0000_0000_0000_0000, 2'd3, 0, '0, 0, '0, '0);
    // R7 R8 load
    step("R7", 0, '0, 0, 0, '0, 1, 64'h0000_8A00_1234_5678, 64'h0000_0000_0040_1000);
    idle("R8");
    // R6 program mask 0xA
    step("R6", 1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 0, '0, 0, '0, '0);
    // R9 insert with load in same cycle
    step("R9", 1, 64'h1111_2222_3333_4444, 2'd0, 0, '0, 1, 64'h0000_0500_0000_0000, 64'h0000_0000_0000_2000);
    step("R9", 1, 64'h1111_2222_3333_4444, 2'd2, 0, '0, 0, '0, '0);
    // R10 load with invalid then valid set-mode
    step("R10", 0, '0, 0, 1, 64'h0000_0000_0000_0200, 1, 64'h0000_C300_0000_00FF, 64'h0000_0000_0000_3000);
    step("R10", 0, '0, 0, 1, 64'h0000_0000_0000_0100, 1, 64'h0000_0100_0000_0000, 64'h0000_0000_0000_4000);
    // R8 back-to-back loads
    step("R8", 0, '0, 0, 0, '0, 1, 64'h0000_4700_0000_0000, 64'h0000_0000_0000_5000);
    idle("R8");
    step("R6", 1, 64'h0123_4567_89AB_CDEF, 2'd3, 0, '0, 0, '0, '0);
    idle("R8");
    idle("R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule